// File: doc/BRIEF.md
# Conditional Atomic Memory Word Unit

This block sits beside a word-organised memory bank and carries out indivisible conditional updates on its 32-bit words. A request names a word and gives two things. The first is a comparison: a relational code plus a compare value, with the stored word on the left-hand side. The second is an update: an operation code plus an operand. The unit fetches the word and evaluates the comparison. Only when the comparison holds does it compute the new value and store it. The response always carries the word as it was before the request, together with a pass flag.

While a sequence runs, every other access to the bank is held off. These are plain loads and stores arriving on a second, ordinary access port. A plain test-and-set is the comparison "always" combined with the "set" update. A lock acquire that only succeeds on a free lock is "equal to zero" combined with "set". The bank is part of the block and is cleared by reset.

Top module: `atomic_tao_unit`

## Requirements
- R1: After reset `busy` and `rsp_valid` are 0, `acc_hold` is 0 while no request is offered, and every memory word reads as 0.
- R2: A request is accepted on a clock edge where `req_valid` is 1 and `busy` is 0. `busy` is then 1 for exactly two cycles. `rsp_valid` is 1 for exactly one cycle: the cycle in which `busy` returns to 0. Any store by the request happens on that same edge.
- R3: The comparison code `req_rel` selects the test applied to the stored word W against `req_cmp`, both unsigned: 0 W==C, 1 W!=C, 2 W<C, 3 W<=C, 4 W>C, 5 W>=C, 6 always true, 7 never true. `rsp_pass` reports its outcome.
- R4: Update code 2 stores W+operand and code 3 stores W-operand, both wrapping modulo 2^32.
- R5: Update code 4 stores W AND operand, code 5 stores W OR operand, code 6 stores W XOR operand.
- R6: Update code 0 stores nothing (a pure read). Code 1 stores the operand. Code 7 stores the value 1, so comparison 6 with update 7 is a test-and-set.
- R7: When the test fails the word is left unchanged and `rsp_pass` is 0.
- R8: `rsp_old` equals the word's value before the request, whether the test passes or fails.
- R9: The plain port (`acc_en`, `acc_we`) is served only in a cycle with `busy` 0 and `req_valid` 0. A served store writes `acc_wdata` at the edge. A served load returns the word in `acc_rdata` with `acc_rvalid` 1 in the next cycle. Otherwise `acc_hold` is 1 and the access has no effect.
- R10: When a request and a plain access are offered in the same cycle, the request is taken and the plain access is held off.
- R11: A request offered while `busy` is 1 is ignored and changes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Atomic request offered |
| req_addr | input | AW | Word index for the request |
| req_rel | input | 3 | Comparison code |
| req_cmp | input | DW | Compare value |
| req_op | input | 3 | Update code |
| req_opnd | input | DW | Update operand |
| busy | output | 1 | A sequence is in progress; new requests are not taken |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pass | output | 1 | Comparison outcome |
| rsp_old | output | DW | Word value before the request |
| acc_en | input | 1 | Plain access request |
| acc_we | input | 1 | Plain access is a store |
| acc_addr | input | AW | Plain access word index |
| acc_wdata | input | DW | Plain store data |
| acc_hold | output | 1 | Plain access not served this cycle |
| acc_rvalid | output | 1 | Plain load data valid |
| acc_rdata | output | DW | Plain load data |

## Verification
Two functions can meet in one cycle. An atomic request and a plain store can be offered together, and a plain store can also arrive while a sequence is still running. The bench provokes both by aiming the plain store at the very word the atomic request targets. It judges the outcome by reading the word back through the plain port afterwards. The word must hold only the atomic result, and `acc_hold` must have been 1 when the store was offered. A second request held on `req_valid` during a sequence is likewise judged at the ports: its target word must read back unchanged.

// File: rtl/atomic_tao_unit.sv
module atomic_tao_unit #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_rel,
  input  logic [DW-1:0] req_cmp,
  input  logic [2:0]    req_op,
  input  logic [DW-1:0] req_opnd,
  output logic          busy,
  output logic          rsp_valid,
  output logic          rsp_pass,
  output logic [DW-1:0] rsp_old,
  input  logic          acc_en,
  input  logic          acc_we,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic          acc_hold,
  output logic          acc_rvalid,
  output logic [DW-1:0] acc_rdata
);

  localparam logic [2:0] REL_EQ = 3'd0, REL_NE = 3'd1, REL_LT = 3'd2, REL_LE = 3'd3,
                         REL_GT = 3'd4, REL_GE = 3'd5, REL_ANY = 3'd6, REL_NONE = 3'd7;
  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_ADD = 3'd2, OP_SUB = 3'd3,
                         OP_AND = 3'd4, OP_OR = 3'd5, OP_XOR = 3'd6, OP_SET = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_EVAL} state_t;

  state_t        state;
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] addr_q;
  logic [2:0]    rel_q, op_q;
  logic [DW-1:0] cmp_q, opnd_q, old_q;
  logic          rsp_q, pass_q;
  logic          test_ok;
  logic [DW-1:0] new_val;
  logic          grant;

  assign busy      = (state != S_IDLE);
  assign grant     = acc_en && !busy && !req_valid;
  assign acc_hold  = acc_en && !grant;
  assign rsp_valid = rsp_q;
  assign rsp_pass  = pass_q;
  assign rsp_old   = old_q;

  always_comb begin
    case (rel_q)
      REL_EQ:  test_ok = (old_q == cmp_q);
      REL_NE:  test_ok = (old_q != cmp_q);
      REL_LT:  test_ok = (old_q <  cmp_q);
      REL_LE:  test_ok = (old_q <= cmp_q);
      REL_GT:  test_ok = (old_q >  cmp_q);
      REL_GE:  test_ok = (old_q >= cmp_q);
      REL_ANY: test_ok = 1'b1;
      default: test_ok = 1'b0;
    endcase
  end

  always_comb begin
    case (op_q)
      OP_RD:   new_val = old_q;
      OP_WR:   new_val = opnd_q;
      OP_ADD:  new_val = old_q + opnd_q;
      OP_SUB:  new_val = old_q - opnd_q;
      OP_AND:  new_val = old_q & opnd_q;
      OP_OR:   new_val = old_q | opnd_q;
      OP_XOR:  new_val = old_q ^ opnd_q;
      default: new_val = DW'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      addr_q     <= '0;
      rel_q      <= REL_NONE;
      op_q       <= OP_RD;
      cmp_q      <= '0;
      opnd_q     <= '0;
      old_q      <= '0;
      rsp_q      <= 1'b0;
      pass_q     <= 1'b0;
      acc_rvalid <= 1'b0;
      acc_rdata  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      rsp_q      <= 1'b0;
      acc_rvalid <= grant && !acc_we;
      if (grant && !acc_we) acc_rdata <= mem[acc_addr];
      if (grant && acc_we)  mem[acc_addr] <= acc_wdata;
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          rel_q  <= req_rel;
          cmp_q  <= req_cmp;
          op_q   <= req_op;
          opnd_q <= req_opnd;
          state  <= S_READ;
        end
        S_READ: begin
          old_q <= mem[addr_q];
          state <= S_EVAL;
        end
        default: begin
          if (test_ok && op_q != OP_RD) mem[addr_q] <= new_val;
          pass_q <= test_ok;
          rsp_q  <= 1'b1;
          state  <= S_IDLE;
        end
      endcase
    end
  end

  p_busy_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 !busy);

  p_rsp_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);

  p_never_fails_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rel_q == REL_NONE) |-> !rsp_pass);

  p_fail_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_pass) |-> mem[addr_q] == rsp_old);

  p_old_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_old == $past(mem[addr_q]));

  p_no_plain_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_READ) |=> mem[addr_q] == old_q);

  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_pass && op_q == OP_WR) |-> mem[addr_q] == opnd_q);

endmodule

// File: tb/tb_atomic_tao_unit.sv
`timescale 1ns/1ps
module tb_atomic_tao_unit;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0]    req_rel = '0;
  logic [DW-1:0] req_cmp = '0;
  logic [2:0]    req_op = '0;
  logic [DW-1:0] req_opnd = '0;
  logic          busy, rsp_valid, rsp_pass;
  logic [DW-1:0] rsp_old;
  logic          acc_en = 1'b0, acc_we = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic          acc_hold, acc_rvalid;
  logic [DW-1:0] acc_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  atomic_tao_unit #(.DW(DW), .DEPTH(16)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_rel(req_rel), .req_cmp(req_cmp),
    .req_op(req_op), .req_opnd(req_opnd),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_pass(rsp_pass), .rsp_old(rsp_old),
    .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_hold(acc_hold), .acc_rvalid(acc_rvalid), .acc_rdata(acc_rdata));

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic plain_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic plain_read(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_en = 1'b0;
    chk({tag, " rvalid"}, DW'(acc_rvalid), DW'(1));
    chk({tag, " rdata"}, acc_rdata, exp);
  endtask

  task automatic atomic(logic [AW-1:0] a, logic [2:0] rel, logic [DW-1:0] c,
                        logic [2:0] op, logic [DW-1:0] o,
                        logic [DW-1:0] exp_old, logic exp_pass, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_rel = rel; req_cmp = c; req_op = op; req_opnd = o;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 busy cycle 1", DW'(busy), DW'(1));
    @(negedge clk);
    chk("R2 busy cycle 2", DW'(busy), DW'(1));
    chk("R2 no early rsp", DW'(rsp_valid), DW'(0));
    @(negedge clk);
    chk("R2 busy falls", DW'(busy), DW'(0));
    chk("R2 rsp strobe", DW'(rsp_valid), DW'(1));
    chk({tag, " old (R8)"}, rsp_old, exp_old);
    chk({tag, " pass"}, DW'(rsp_pass), DW'(exp_pass));
    @(negedge clk);
    chk("R2 rsp one cycle", DW'(rsp_valid), DW'(0));
  endtask

  task automatic t_reset;
    chk("R1 busy", DW'(busy), DW'(0));
    chk("R1 rsp_valid", DW'(rsp_valid), DW'(0));
    chk("R1 acc_hold", DW'(acc_hold), DW'(0));
    plain_read(4'd3, 32'h0, "R1 cleared word");
  endtask

  task automatic t_plain;
    plain_write(4'd2, 32'd100);
    plain_read(4'd2, 32'd100, "R9 plain store");
  endtask

  task automatic t_compare_arith;
    atomic(4'd2, 3'd5, 32'd50, 3'd2, 32'd5, 32'd100, 1'b1, "R3 ge/R4 add");
    plain_read(4'd2, 32'd105, "R4 add result");
    atomic(4'd2, 3'd2, 32'd50, 3'd3, 32'd1, 32'd105, 1'b0, "R7 lt fails");
    plain_read(4'd2, 32'd105, "R7 unchanged");
    atomic(4'd2, 3'd3, 32'd105, 3'd1, 32'd7, 32'd105, 1'b1, "R3 le/R6 write");
    plain_read(4'd2, 32'd7, "R6 write result");
  endtask

  task automatic t_unsigned_wrap;
    plain_write(4'd4, 32'hFFFF_FFF0);
    atomic(4'd4, 3'd4, 32'd1, 3'd2, 32'h20, 32'hFFFF_FFF0, 1'b1, "R3 unsigned gt");
    plain_read(4'd4, 32'h10, "R4 add wraps");
    atomic(4'd5, 3'd0, 32'd0, 3'd3, 32'd1, 32'd0, 1'b1, "R3 eq");
    plain_read(4'd5, 32'hFFFF_FFFF, "R4 sub wraps");
  endtask

  task automatic t_logic;
    plain_write(4'd6, 32'hF0F0);
    atomic(4'd6, 3'd1, 32'd0, 3'd4, 32'hFF00, 32'hF0F0, 1'b1, "R3 ne/R5 and");
    plain_read(4'd6, 32'hF000, "R5 and");
    atomic(4'd6, 3'd6, 32'd0, 3'd5, 32'h000F, 32'hF000, 1'b1, "R5 or");
    plain_read(4'd6, 32'hF00F, "R5 or");
    atomic(4'd6, 3'd6, 32'd0, 3'd6, 32'hFFFF, 32'hF00F, 1'b1, "R5 xor");
    plain_read(4'd6, 32'h0FF0, "R5 xor");
  endtask

  task automatic t_tas_read_never;
    atomic(4'd7, 3'd6, 32'd0, 3'd7, 32'd0, 32'd0, 1'b1, "R6 tas first");
    plain_read(4'd7, 32'd1, "R6 tas sets");
    atomic(4'd7, 3'd6, 32'd0, 3'd7, 32'd0, 32'd1, 1'b1, "R6 tas again");
    atomic(4'd7, 3'd0, 32'd0, 3'd7, 32'd0, 32'd1, 1'b0, "R7 lock taken");
    atomic(4'd6, 3'd7, 32'd0, 3'd1, 32'd9, 32'h0FF0, 1'b0, "R3 never");
    plain_read(4'd6, 32'h0FF0, "R7 never unchanged");
    atomic(4'd6, 3'd6, 32'd0, 3'd0, 32'd9, 32'h0FF0, 1'b1, "R6 read op");
    plain_read(4'd6, 32'h0FF0, "R6 read no store");
  endtask

  task automatic t_collision;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 4'd8; req_rel = 3'd6; req_op = 3'd1; req_opnd = 32'h55;
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = 4'd8; acc_wdata = 32'hAA;
    #1 chk("R10 hold on collision", DW'(acc_hold), DW'(1));
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 hold while busy", DW'(acc_hold), DW'(1));
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
    @(negedge clk);
    chk("R10 rsp", DW'(rsp_valid), DW'(1));
    plain_read(4'd8, 32'h55, "R10 atomic wins");
  endtask

  task automatic t_busy_ignore;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 4'd9; req_rel = 3'd6; req_op = 3'd2; req_opnd = 32'd1;
    @(negedge clk);
    req_addr = 4'd10; req_op = 3'd1; req_opnd = 32'h77;
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = 4'd11; acc_wdata = 32'h33;
    @(negedge clk);
    @(negedge clk);
    chk("R11 rsp", DW'(rsp_valid), DW'(1));
    req_valid = 1'b0; acc_en = 1'b0; acc_we = 1'b0;
    @(negedge clk);
    chk("R11 not restarted", DW'(busy), DW'(0));
    plain_read(4'd9, 32'd1, "R11 first done");
    plain_read(4'd10, 32'd0, "R11 second ignored");
    plain_read(4'd11, 32'd0, "R9 store during busy ignored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_compare_arith();
    t_unsigned_wrap();
    t_logic();
    t_tas_read_never();
    t_collision();
    t_busy_ignore();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule